// File: doc/BRIEF.md
# Multiplexed YCrCb Pixel Port Demultiplexer

This block sits at the front of a video encoder datapath. It takes 4:2:2 YCrCb samples from a pixel port that is either one byte lane or two byte lanes wide. It rebuilds each pair of chroma and luma, so the datapath behind it sees one luma sample and its chroma companion together, with a tag that says whether the chroma is Cb or Cr.

Components repeat in the cycle Cb, Y, Cr, Y. On the narrow port, every component has its own clock on the low byte lane. On the wide port, the low lane carries luma and the high lane carries chroma, with Cb and Cr alternating. Data is captured on every second rising edge. A synchronous alignment pulse restarts the component phase. A requested change of port width is applied only on that same pulse, so no sample group mixes the two formats.

Top module: `ycc_port_demux`

## Requirements
- R1: While reset is high and on the first cycle after it, `pair_vld_o` is low. Reset selects the narrow (8-bit) port and the Cb phase.
- R2: In narrow mode the byte sequence on `pix_i[7:0]` is taken as Cb, Y, Cr, Y. On the cycle after each Y byte, `luma_o` equals that Y byte and `chroma_o` equals the chroma byte just before it. `chroma_is_cr_o` is 0 (Cb) for the first pair and 1 (Cr) for the second.
- R3: In narrow mode `pair_vld_o` pulses for exactly one cycle per luma byte, so a steady stream gives a pulse every second cycle, one cycle after the Y byte.
- R4: In wide mode, `luma_o` takes `pix_i[7:0]` and `chroma_o` takes `pix_i[15:8]`. They are captured on the alignment cycle and then on every second cycle after it. The port contents on the other cycles have no effect on the outputs.
- R5: In wide mode the chroma tag alternates between Cb (0) and Cr (1) over successive captures, starting with Cb at alignment.
- R6: When `align_i` is high, that cycle's sample is taken as the Cb phase, whatever the phase was before.
- R7: `wide_mode_i` (0 = narrow, 1 = wide) is applied only on a cycle where `align_i` is high. Changes on other cycles are ignored.
- R8: Between valid pulses, `luma_o`, `chroma_o` and `chroma_is_cr_o` hold their last values.
- R9: After reset with no alignment pulse, the first narrow byte is taken as Cb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode_i | input | 1 | Requested width: 0 = 8-bit, 1 = 16-bit; sampled on alignment |
| align_i | input | 1 | Phase restart; this cycle is Cb |
| pix_i | input | 2*DW | Pixel port; low lane luma or all components, high lane chroma |
| luma_o | output | DW | Rebuilt luma sample |
| chroma_o | output | DW | Chroma sample paired with luma_o |
| chroma_is_cr_o | output | 1 | 0 = Cb, 1 = Cr |
| pair_vld_o | output | 1 | One-cycle strobe per completed luma sample |

## Verification
The hardest case to reach is a width request that changes in the middle of a group. The stimulus drops `wide_mode_i` while the block is in wide mode with no alignment pulse, and checks that capture stays on the wide cadence and lanes. It then aligns to the narrow port and checks the narrow ordering. A second hard case is an alignment pulse in the middle of a group. The bench sends a Cr byte, then aligns on the next byte, and checks that this byte is paired as Cb with the luma that follows.

// File: rtl/ycc_demux_pkg.sv
package ycc_demux_pkg;
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;
endpackage

// File: rtl/ycc_phase_ctrl.sv
module ycc_phase_ctrl
  import ycc_demux_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   align_i,
  input  logic   wide_req_i,
  output logic   wide_o,
  output phase_e phase_o
);
  logic   wide_q;
  phase_e cnt_q;

  // alignment cycle uses the requested width and the Cb phase at once
  always_comb begin
    wide_o  = align_i ? wide_req_i : wide_q;
    phase_o = align_i ? PH_CB : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b0;
      cnt_q  <= PH_CB;
    end else begin
      wide_q <= wide_o;
      cnt_q  <= phase_e'(2'(phase_o + 2'd1));
    end
  end

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !align_i |=> (wide_q == $past(wide_q)));

  // R6
  align_phase_chk: assert property (@(posedge clk) disable iff (rst)
    align_i |=> (cnt_q == PH_Y0));
endmodule

// File: rtl/ycc_chroma_hold.sv
module ycc_chroma_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] hold_o
);
  always_ff @(posedge clk) begin
    if (rst)         hold_o <= '0;
    else if (load_i) hold_o <= data_i;
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(hold_o));
endmodule

// File: rtl/ycc_group_out.sv
module ycc_group_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic [DW-1:0] luma_i,
  input  logic [DW-1:0] chroma_i,
  input  logic          is_cr_i,
  output logic [DW-1:0] luma_o,
  output logic [DW-1:0] chroma_o,
  output logic          is_cr_o,
  output logic          vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      luma_o   <= '0;
      chroma_o <= '0;
      is_cr_o  <= 1'b0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= fire_i;
      if (fire_i) begin
        luma_o   <= luma_i;
        chroma_o <= chroma_i;
        is_cr_o  <= is_cr_i;
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> ($stable(luma_o) && $stable(chroma_o) && $stable(is_cr_o)));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !vld_o);
endmodule

// File: rtl/ycc_port_demux.sv
module ycc_port_demux
  import ycc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide_mode_i,
  input  logic            align_i,
  input  logic [2*DW-1:0] pix_i,
  output logic [DW-1:0]   luma_o,
  output logic [DW-1:0]   chroma_o,
  output logic            chroma_is_cr_o,
  output logic            pair_vld_o
);
  localparam int LO = 0;
  localparam int HI = DW;

  logic          wide;
  phase_e        phase;
  logic          fire;
  logic          chroma_load;
  logic [DW-1:0] chroma_held;
  logic [DW-1:0] chroma_src;
  logic [DW-1:0] lane_lo;
  logic [DW-1:0] lane_hi;

  assign lane_lo = pix_i[LO +: DW];
  assign lane_hi = pix_i[HI +: DW];

  ycc_phase_ctrl u_phase (
    .clk        (clk),
    .rst        (rst),
    .align_i    (align_i),
    .wide_req_i (wide_mode_i),
    .wide_o     (wide),
    .phase_o    (phase)
  );

  // narrow: Y on odd phases; wide: capture on even phases
  always_comb begin
    fire        = wide ? ~phase[0] : phase[0];
    chroma_load = ~wide & ~phase[0];
    chroma_src  = wide ? lane_hi : chroma_held;
  end

  ycc_chroma_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (chroma_load),
    .data_i (lane_lo),
    .hold_o (chroma_held)
  );

  ycc_group_out #(.DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire_i   (fire),
    .luma_i   (lane_lo),
    .chroma_i (chroma_src),
    .is_cr_i  (phase[1]),
    .luma_o   (luma_o),
    .chroma_o (chroma_o),
    .is_cr_o  (chroma_is_cr_o),
    .vld_o    (pair_vld_o)
  );

  // R2
  luma_lane_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (pair_vld_o && luma_o == $past(lane_lo)));

  // R4
  wide_chroma_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && wide) |=> (chroma_o == $past(lane_hi)));
endmodule

// File: tb/ycc_port_demux_bench.sv
`timescale 1ns/1ps
module ycc_port_demux_bench;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wide_mode_i = 1'b0;
  logic            align_i = 1'b0;
  logic [2*DW-1:0] pix_i = '0;
  logic [DW-1:0]   luma_o;
  logic [DW-1:0]   chroma_o;
  logic            chroma_is_cr_o;
  logic            pair_vld_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ycc_port_demux #(.DW(DW)) u_ycc_port_demux (
    .clk            (clk),
    .rst            (rst),
    .wide_mode_i    (wide_mode_i),
    .align_i        (align_i),
    .pix_i          (pix_i),
    .luma_o         (luma_o),
    .chroma_o       (chroma_o),
    .chroma_is_cr_o (chroma_is_cr_o),
    .pair_vld_o     (pair_vld_o)
  );

  // drive one cycle, return after the capturing edge
  task automatic step(input logic [2*DW-1:0] p, input logic al, input logic wm);
    pix_i = p; align_i = al; wide_mode_i = wm;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic v, input logic [DW-1:0] y,
                            input logic [DW-1:0] c, input logic cr);
    n_run++;
    if (pair_vld_o !== v || luma_o !== y || chroma_o !== c || chroma_is_cr_o !== cr) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b y=%h c=%h cr=%0b, expected vld=%0b y=%h c=%h cr=%0b",
               req, pair_vld_o, luma_o, chroma_o, chroma_is_cr_o, v, y, c, cr);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; align_i = 1'b0; wide_mode_i = 1'b0; pix_i = '0;
    repeat (3) @(negedge clk);
    expect_out("R1 during reset", 1'b0, 8'h00, 8'h00, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset_default();
    step(16'h0012, 1'b0, 1'b0);
    expect_out("R1 first cycle after reset", 1'b0, 8'h00, 8'h00, 1'b0);
    step(16'h0034, 1'b0, 1'b0);
    expect_out("R9 first byte is Cb", 1'b1, 8'h34, 8'h12, 1'b0);
  endtask

  task automatic t_narrow_stream();
    step(16'h0010, 1'b1, 1'b0);
    expect_out("R3 no strobe on Cb byte", 1'b0, 8'h34, 8'h12, 1'b0);
    step(16'h0020, 1'b0, 1'b0);
    expect_out("R2 Cb/Y0 pair", 1'b1, 8'h20, 8'h10, 1'b0);
    step(16'h0030, 1'b0, 1'b0);
    expect_out("R8 hold on Cr byte", 1'b0, 8'h20, 8'h10, 1'b0);
    step(16'h0040, 1'b0, 1'b0);
    expect_out("R2 Cr/Y1 pair", 1'b1, 8'h40, 8'h30, 1'b1);
    step(16'h0051, 1'b0, 1'b0);
    expect_out("R3 no strobe", 1'b0, 8'h40, 8'h30, 1'b1);
    step(16'h0062, 1'b0, 1'b0);
    expect_out("R3 next group pair", 1'b1, 8'h62, 8'h51, 1'b0);
  endtask

  task automatic t_realign();
    step(16'h0073, 1'b0, 1'b0);   // Cr
    step(16'h0055, 1'b1, 1'b0);   // realigned: Cb
    expect_out("R6 align cycle silent", 1'b0, 8'h62, 8'h51, 1'b0);
    step(16'h0066, 1'b0, 1'b0);
    expect_out("R6 aligned byte is Cb", 1'b1, 8'h66, 8'h55, 1'b0);
  endtask

  task automatic t_wide_stream();
    step(16'h8011, 1'b1, 1'b1);
    expect_out("R4 wide capture on align", 1'b1, 8'h11, 8'h80, 1'b0);
    step(16'hFFFF, 1'b0, 1'b1);
    expect_out("R4 off cycle ignored", 1'b0, 8'h11, 8'h80, 1'b0);
    step(16'h9022, 1'b0, 1'b1);
    expect_out("R5 wide Cr capture", 1'b1, 8'h22, 8'h90, 1'b1);
    step(16'hEEEE, 1'b0, 1'b1);
    expect_out("R4 off cycle ignored", 1'b0, 8'h22, 8'h90, 1'b1);
    step(16'hA033, 1'b0, 1'b1);
    expect_out("R5 wide back to Cb", 1'b1, 8'h33, 8'hA0, 1'b0);
  endtask

  task automatic t_mode_change();
    step(16'hDDDD, 1'b0, 1'b0);   // width request drops, no align
    expect_out("R7 ignored request, off cycle", 1'b0, 8'h33, 8'hA0, 1'b0);
    step(16'hB044, 1'b0, 1'b0);
    expect_out("R7 still wide capture", 1'b1, 8'h44, 8'hB0, 1'b1);
    step(16'h0077, 1'b1, 1'b0);   // narrow takes effect here, Cb
    expect_out("R7 narrow after align", 1'b0, 8'h44, 8'hB0, 1'b1);
    step(16'hCC88, 1'b0, 1'b0);
    expect_out("R7 narrow pairing", 1'b1, 8'h88, 8'h77, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_reset_default();
    t_narrow_stream();
    t_realign();
    t_wide_stream();
    t_mode_change();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule